// File: doc/BRIEF.md
# DMA event gate and completion interrupt front end

This block sits in front of a 64-channel DMA transfer engine. Each channel has an active-low external event pin. The block catches a falling edge on that pin and latches it in a per-channel event bit. Software can also raise a channel through an event-set write. An enabled or software-raised event becomes a channel request toward the engine. Only one request is issued per cycle, and the lowest channel number is served first. When a second event lands on a bit that is still latched, it is not lost silently: it raises a sticky miss flag for that channel.

On the completion side, the engine reports each finished transfer with a 6-bit completion code and a flag that says whether the transfer wants an interrupt. The block sets the pending bit named by that code. The enable bits are indexed by the same code. The single global interrupt line is high while any pending bit is also enabled.

All registers are written through one port. A register select picks the register, a word select picks channels or codes 0–31 (word 0) or 32–63 (word 1), and a 32-bit data mask carries the write. Every register is write-1-to-set or write-1-to-clear.

Top module: `dma_event_front`

## Requirements
- R1: Each 64-bit register is written 32 bits at a time. `wr_word`=0 addresses bits 0–31 and `wr_word`=1 addresses bits 32–63. Bit b of word w therefore maps to channel or code 32·w+b; for example, channel 52 is bit 20 of word 1.
- R2: A high-to-low transition of `ext_evt_n[c]`, sampled on consecutive clock edges, sets `evt_latched[c]` at the second of those edges. This happens whether or not the channel is enabled.
- R3: A latched event on a channel whose `chan_en` bit is 0 produces no request and stays latched.
- R4: A write with `wr_sel`=0 (event set) latches the marked channels and requests them even when they are not enabled. It does not change `chan_en`.
- R5: A grant raises `req_valid` for one cycle, with `req_ch` holding the channel number, in the cycle after the event became requestable. At the same edge the grant clears that channel's `evt_latched` bit.
- R6: When several channels are requestable at once, requests are issued on consecutive cycles, one per cycle, in ascending channel order.
- R7: An event (pin edge or event-set write) on a channel whose `evt_latched` bit is already set, and is not being granted, sets `evt_miss` for that channel. The flag stays set until a write with `wr_sel`=6 clears it.
- R8: A report with `cmp_valid`=1 and `cmp_int`=1 sets `irq_pend[cmp_code]` at that edge. With `cmp_int`=0 the report leaves `irq_pend` unchanged.
- R9: `irq_out` is high exactly while some bit is set in both `irq_pend` and `irq_en`. The `irq_en` bits are indexed by completion code and are set by `wr_sel`=3 and cleared by `wr_sel`=4.
- R10: A pending bit clears only through a write with `wr_sel`=5 (write-1-to-clear). A completion that posts a bit in the same cycle as a clear of that bit leaves the bit set. `irq_out` stays high for as long as an enabled pending bit remains.
- R11: Register selects are: 0 event set, 1 channel-enable set, 2 channel-enable clear, 3 interrupt-enable set, 4 interrupt-enable clear, 5 pending clear, 6 miss clear. Bits whose mask bit is 0, and the other word, are left untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_evt_n | input | 64 | Per-channel active-low event pins, falling edge significant |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select (see R11) |
| wr_word | input | 1 | Word select: 0 for bits 0–31, 1 for bits 32–63 |
| wr_data | input | 32 | Write mask |
| cmp_valid | input | 1 | Completion report strobe from the transfer engine |
| cmp_code | input | 6 | Completion code of the report |
| cmp_int | input | 1 | Report requests an interrupt |
| req_valid | output | 1 | Channel request pulse to the transfer engine |
| req_ch | output | 6 | Requested channel number |
| evt_latched | output | 64 | Latched event bits |
| evt_miss | output | 64 | Sticky per-channel miss flags |
| chan_en | output | 64 | Channel event-enable bits |
| irq_en | output | 64 | Interrupt-enable bits, indexed by completion code |
| irq_pend | output | 64 | Interrupt-pending bits, indexed by completion code |
| irq_out | output | 1 | Global completion interrupt |

## Verification
The bench builds the block with its default values: 64 channels, 32-bit words and 6-bit codes. With these values both register words are in use, so channels and codes on either side of the 31/32 boundary can be reached, including channel 52 in the high word. Codes 0, 31, 32 and 63 mark the ends of the code space and are driven through the completion vector table. Simultaneous edges on channels 2, 5 and 40 exercise the ordering across both words.

// File: rtl/dma_evt_pkg.sv
package dma_evt_pkg;

  // Register select codes on the write port
  typedef enum logic [2:0] {
    SEL_EVT_SET  = 3'd0,
    SEL_EN_SET   = 3'd1,
    SEL_EN_CLR   = 3'd2,
    SEL_IE_SET   = 3'd3,
    SEL_IE_CLR   = 3'd4,
    SEL_PEND_CLR = 3'd5,
    SEL_MISS_CLR = 3'd6
  } wr_sel_e;

endpackage

// File: rtl/evt_latch.sv
module evt_latch #(
  parameter int NUM_CH = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] pin_n,
  input  logic [NUM_CH-1:0] sw_set,
  input  logic [NUM_CH-1:0] en_set,
  input  logic [NUM_CH-1:0] en_clr,
  input  logic [NUM_CH-1:0] miss_clr,
  input  logic [NUM_CH-1:0] grant_v,
  output logic [NUM_CH-1:0] evt_q,
  output logic [NUM_CH-1:0] force_q,
  output logic [NUM_CH-1:0] en_q,
  output logic [NUM_CH-1:0] miss_q
);

  logic [NUM_CH-1:0] pin_prev;
  // named internal events for checking
  logic [NUM_CH-1:0] edge_v;   // falling edges seen this cycle
  logic [NUM_CH-1:0] new_v;    // any new event source
  logic [NUM_CH-1:0] hit_v;    // new event on a still-latched bit

  assign edge_v = pin_prev & ~pin_n;
  assign new_v  = edge_v | sw_set;
  assign hit_v  = new_v & evt_q & ~grant_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_prev <= '1;
      evt_q    <= '0;
      force_q  <= '0;
      en_q     <= '0;
      miss_q   <= '0;
    end else begin
      pin_prev <= pin_n;
      evt_q    <= (evt_q & ~grant_v) | new_v;
      force_q  <= (force_q & ~grant_v) | sw_set;
      en_q     <= (en_q | en_set) & ~en_clr;
      miss_q   <= (miss_q & ~miss_clr) | hit_v;
    end
  end

  // R2: every detected edge or software set shows up in the event register
  assert_edge_latched_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((evt_q & $past(new_v)) == $past(new_v)));

  // R7: a collision leaves the miss flag set
  assert_miss_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((miss_q & $past(hit_v)) == $past(hit_v)));

  // R7: a miss flag only drops after a miss-clear write
  assert_miss_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(miss_q) & ~miss_q)) |-> $past(|miss_clr));

endmodule

// File: rtl/evt_arbiter.sv
module evt_arbiter #(
  parameter int NUM_CH = 64
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_CH-1:0]         evt_q,
  input  logic [NUM_CH-1:0]         force_q,
  input  logic [NUM_CH-1:0]         en_q,
  output logic [NUM_CH-1:0]         grant_v,
  output logic                      req_valid,
  output logic [$clog2(NUM_CH)-1:0] req_ch
);

  localparam int CH_W = $clog2(NUM_CH);
  localparam logic [NUM_CH-1:0] ONE = NUM_CH'(1);

  // lowest set bit: {found, index}
  function automatic logic [CH_W:0] pick_lowest(input logic [NUM_CH-1:0] v);
    logic [CH_W:0] r;
    r = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (v[i]) r = {1'b1, CH_W'(i)};
    end
    return r;
  endfunction

  logic [NUM_CH-1:0] elig_v;
  logic [CH_W:0]     pick;

  assign elig_v  = evt_q & (en_q | force_q);
  assign pick    = pick_lowest(elig_v);
  assign grant_v = pick[CH_W] ? (ONE << pick[CH_W-1:0]) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_valid <= 1'b0;
      req_ch    <= '0;
    end else begin
      req_valid <= pick[CH_W];
      req_ch    <= pick[CH_W-1:0];
    end
  end

  // R3 / R4: a requested channel was enabled-or-forced and latched
  assert_grant_eligible_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> ((($past(elig_v) >> req_ch) & ONE) != '0));

  // R6: no lower channel was waiting when this one was picked
  assert_lowest_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (($past(elig_v) & ((ONE << req_ch) - ONE)) == '0));

  // R5: the granted bit is gone from the event register unless re-armed
  assert_grant_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (!evt_q[req_ch] || $past(req_valid)));

endmodule

// File: rtl/cmp_irq.sv
module cmp_irq #(
  parameter int CODE_W = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cmp_valid,
  input  logic [CODE_W-1:0]      cmp_code,
  input  logic                   cmp_int,
  input  logic [(1<<CODE_W)-1:0] ie_set,
  input  logic [(1<<CODE_W)-1:0] ie_clr,
  input  logic [(1<<CODE_W)-1:0] pend_clr,
  output logic [(1<<CODE_W)-1:0] pend_q,
  output logic [(1<<CODE_W)-1:0] ie_q,
  output logic                   irq_out
);

  localparam int NUM_CODE = 1 << CODE_W;
  localparam logic [NUM_CODE-1:0] ONE = NUM_CODE'(1);

  logic [NUM_CODE-1:0] post_v;   // bit posted by this cycle's report

  assign post_v  = (cmp_valid && cmp_int) ? (ONE << cmp_code) : '0;
  assign irq_out = |(pend_q & ie_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      ie_q   <= '0;
    end else begin
      pend_q <= (pend_q & ~pend_clr) | post_v;
      ie_q   <= (ie_q | ie_set) & ~ie_clr;
    end
  end

  // R8: a report that asks for an interrupt leaves its code pending
  assert_code_posted_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && cmp_int) |=> pend_q[$past(cmp_code)]);

  // R10: pending bits fall only after a pending-clear write
  assert_pend_w1c_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(pend_q) & ~pend_q)) |-> $past(|pend_clr));

  // R9: the line rises only after a posting or an enable write
  assert_irq_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_out) |-> ($past(cmp_valid && cmp_int) || $past(|ie_set)));

endmodule

// File: rtl/dma_event_front.sv
module dma_event_front #(
  parameter int NUM_CH = 64,
  parameter int WORD_W = 32,
  parameter int CODE_W = 6
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_CH-1:0]             ext_evt_n,
  input  logic                          wr_en,
  input  logic [2:0]                    wr_sel,
  input  logic                          wr_word,
  input  logic [WORD_W-1:0]             wr_data,
  input  logic                          cmp_valid,
  input  logic [CODE_W-1:0]             cmp_code,
  input  logic                          cmp_int,
  output logic                          req_valid,
  output logic [$clog2(NUM_CH)-1:0]     req_ch,
  output logic [NUM_CH-1:0]             evt_latched,
  output logic [NUM_CH-1:0]             evt_miss,
  output logic [NUM_CH-1:0]             chan_en,
  output logic [(1<<CODE_W)-1:0]        irq_en,
  output logic [(1<<CODE_W)-1:0]        irq_pend,
  output logic                          irq_out
);

  import dma_evt_pkg::*;

  localparam int NUM_CODE = 1 << CODE_W;
  localparam int CH_WORDS = NUM_CH / WORD_W;
  localparam int CD_WORDS = NUM_CODE / WORD_W;

  logic [NUM_CH-1:0]   ch_mask;
  logic [NUM_CODE-1:0] cd_mask;

  // spread the written word into the full-width masks
  for (genvar w = 0; w < CH_WORDS; w++) begin : g_ch_word
    assign ch_mask[w*WORD_W +: WORD_W] = (wr_word == 1'(w)) ? wr_data : '0;
  end
  for (genvar w = 0; w < CD_WORDS; w++) begin : g_cd_word
    assign cd_mask[w*WORD_W +: WORD_W] = (wr_word == 1'(w)) ? wr_data : '0;
  end

  logic [NUM_CH-1:0]   sw_set, en_set, en_clr, miss_clr, grant_v, force_q;
  logic [NUM_CODE-1:0] ie_set, ie_clr, pend_clr;

  assign sw_set   = (wr_en && wr_sel == SEL_EVT_SET)  ? ch_mask : '0;
  assign en_set   = (wr_en && wr_sel == SEL_EN_SET)   ? ch_mask : '0;
  assign en_clr   = (wr_en && wr_sel == SEL_EN_CLR)   ? ch_mask : '0;
  assign miss_clr = (wr_en && wr_sel == SEL_MISS_CLR) ? ch_mask : '0;
  assign ie_set   = (wr_en && wr_sel == SEL_IE_SET)   ? cd_mask : '0;
  assign ie_clr   = (wr_en && wr_sel == SEL_IE_CLR)   ? cd_mask : '0;
  assign pend_clr = (wr_en && wr_sel == SEL_PEND_CLR) ? cd_mask : '0;

  evt_latch #(.NUM_CH(NUM_CH)) u_latch (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin_n    (ext_evt_n),
    .sw_set   (sw_set),
    .en_set   (en_set),
    .en_clr   (en_clr),
    .miss_clr (miss_clr),
    .grant_v  (grant_v),
    .evt_q    (evt_latched),
    .force_q  (force_q),
    .en_q     (chan_en),
    .miss_q   (evt_miss)
  );

  evt_arbiter #(.NUM_CH(NUM_CH)) u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_q     (evt_latched),
    .force_q   (force_q),
    .en_q      (chan_en),
    .grant_v   (grant_v),
    .req_valid (req_valid),
    .req_ch    (req_ch)
  );

  cmp_irq #(.CODE_W(CODE_W)) u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmp_valid (cmp_valid),
    .cmp_code  (cmp_code),
    .cmp_int   (cmp_int),
    .ie_set    (ie_set),
    .ie_clr    (ie_clr),
    .pend_clr  (pend_clr),
    .pend_q    (irq_pend),
    .ie_q      (irq_en),
    .irq_out   (irq_out)
  );

  // R11: one write touches only the selected register
  assert_single_target_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel != SEL_EN_SET && wr_sel != SEL_EN_CLR) |=> $stable(chan_en));

endmodule

// File: tb/test_dma_event_front.sv
module test_dma_event_front;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] ext_evt_n = '1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_sel = '0;
  logic        wr_word = 1'b0;
  logic [31:0] wr_data = '0;
  logic        cmp_valid = 1'b0;
  logic [5:0]  cmp_code = '0;
  logic        cmp_int = 1'b0;
  logic        req_valid;
  logic [5:0]  req_ch;
  logic [63:0] evt_latched, evt_miss, chan_en, irq_en, irq_pend;
  logic        irq_out;

  int n_run = 0;
  int n_fail = 0;
  int req_n = 0;
  logic [5:0] req_log [16];
  bit done = 0;

  always #2 clk = ~clk;   // 250 MHz

  dma_event_front i_dma_event_front (
    .clk(clk), .rst_n(rst_n), .ext_evt_n(ext_evt_n),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_word(wr_word), .wr_data(wr_data),
    .cmp_valid(cmp_valid), .cmp_code(cmp_code), .cmp_int(cmp_int),
    .req_valid(req_valid), .req_ch(req_ch),
    .evt_latched(evt_latched), .evt_miss(evt_miss), .chan_en(chan_en),
    .irq_en(irq_en), .irq_pend(irq_pend), .irq_out(irq_out)
  );

  // request monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (rst_n && req_valid) begin
      if (req_n < 16) req_log[req_n] = req_ch;
      req_n = req_n + 1;
    end
  end

  // completion vectors: {code[5:0], cmp_int, expected pending, expected irq}
  // interrupt enables are set for codes 3, 31, 52, 63
  localparam logic [8:0] VEC [8] = '{
    {6'd3,  1'b1, 1'b1, 1'b1},
    {6'd4,  1'b1, 1'b1, 1'b0},
    {6'd52, 1'b1, 1'b1, 1'b1},
    {6'd52, 1'b0, 1'b0, 1'b0},
    {6'd32, 1'b1, 1'b1, 1'b0},
    {6'd63, 1'b1, 1'b1, 1'b1},
    {6'd31, 1'b1, 1'b1, 1'b1},
    {6'd0,  1'b0, 1'b0, 1'b0}
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic word, input logic [31:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_word = word; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic complete(input logic [5:0] code, input logic want_int);
    @(negedge clk);
    cmp_valid = 1'b1; cmp_code = code; cmp_int = want_int;
    @(negedge clk);
    cmp_valid = 1'b0; cmp_int = 1'b0;
  endtask

  task automatic pulse_pins(input logic [63:0] mask);
    @(negedge clk);
    ext_evt_n = ext_evt_n & ~mask;
    @(negedge clk);
    ext_evt_n = ext_evt_n | mask;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    chk("R5 reset req_valid", 64'(req_valid), 64'd0);
    chk("R2 reset evt_latched", evt_latched, 64'd0);
    chk("R9 reset irq_out/pend", {irq_pend[62:0], irq_out}, 64'd0);

    // R2 / R3: edge on disabled channel 52 latches, no request
    req_n = 0;
    pulse_pins(64'd1 << 52);
    chk("R2 edge latches ch52", evt_latched, 64'd1 << 52);
    idle(4);
    chk("R3 no request while disabled", 64'(req_n), 64'd0);
    chk("R3 event held", evt_latched, 64'd1 << 52);

    // R1 / R5: enable ch52 through bit 20 of word 1
    wr(3'd1, 1'b1, 32'd1 << 20);
    chk("R1 ch52 enable from high word", chan_en, 64'd1 << 52);
    idle(3);
    chk("R5 one request", 64'(req_n), 64'd1);
    chk("R5 request channel", 64'(req_log[0]), 64'd52);
    chk("R5 event cleared by grant", evt_latched, 64'd0);

    // R11: masked set and clear
    wr(3'd1, 1'b0, 32'h5);
    chk("R11 enable set word0", chan_en, (64'd1 << 52) | 64'h5);
    wr(3'd2, 1'b0, 32'h1);
    chk("R11 enable clear bit0 only", chan_en, (64'd1 << 52) | 64'h4);

    // R6: simultaneous events on 40, 5, 2
    wr(3'd1, 1'b0, 32'd1 << 5);
    wr(3'd1, 1'b1, 32'd1 << 8);
    req_n = 0;
    pulse_pins((64'd1 << 40) | (64'd1 << 5) | (64'd1 << 2));
    idle(6);
    chk("R6 three requests", 64'(req_n), 64'd3);
    chk("R6 order", {40'd0, req_log[0], req_log[1], req_log[2], 6'd0}, {40'd0, 6'd2, 6'd5, 6'd40, 6'd0});
    chk("R6 all cleared", evt_latched, 64'd0);

    // R4: software set on disabled channel 9
    req_n = 0;
    wr(3'd0, 1'b0, 32'd1 << 9);
    idle(3);
    chk("R4 forced request count", 64'(req_n), 64'd1);
    chk("R4 forced channel", 64'(req_log[0]), 64'd9);
    chk("R4 enable untouched", 64'(chan_en[9]), 64'd0);
    chk("R4 event cleared", evt_latched, 64'd0);

    // R7: double event on disabled channel 60
    req_n = 0;
    pulse_pins(64'd1 << 60);
    chk("R7 no miss on first event", evt_miss, 64'd0);
    pulse_pins(64'd1 << 60);
    idle(1);
    chk("R7 miss set", evt_miss, 64'd1 << 60);
    idle(3);
    chk("R7 miss sticky", evt_miss, 64'd1 << 60);
    wr(3'd6, 1'b1, 32'd1 << 28);
    chk("R7 miss cleared", evt_miss, 64'd0);
    chk("R11 event untouched by miss clear", evt_latched, 64'd1 << 60);
    chk("R3 no request for ch60", 64'(req_n), 64'd0);

    // R8 / R9 vector table
    wr(3'd3, 1'b0, 32'h8000_0008);
    wr(3'd3, 1'b1, 32'h8010_0000);
    chk("R9 enables by code", irq_en, 64'h8010_0000_8000_0008);
    for (int i = 0; i < 8; i++) begin
      complete(VEC[i][8:3], VEC[i][2]);
      chk($sformatf("R8 vec %0d pending", i), 64'(irq_pend[VEC[i][8:3]]), 64'(VEC[i][1]));
      chk($sformatf("R9 vec %0d irq", i), 64'(irq_out), 64'(VEC[i][0]));
      wr(3'd5, VEC[i][8], 32'd1 << VEC[i][7:3]);
      chk($sformatf("R10 vec %0d cleared", i), irq_pend, 64'd0);
    end

    // R10: set wins over same-cycle clear, irq holds
    complete(6'd52, 1'b1);
    @(negedge clk);
    cmp_valid = 1'b1; cmp_code = 6'd52; cmp_int = 1'b1;
    wr_en = 1'b1; wr_sel = 3'd5; wr_word = 1'b1; wr_data = 32'd1 << 20;
    @(negedge clk);
    cmp_valid = 1'b0; cmp_int = 1'b0; wr_en = 1'b0; wr_data = '0;
    chk("R10 post beats clear", irq_pend, 64'd1 << 52);
    wr(3'd5, 1'b0, 32'd1 << 3);
    chk("R11 unrelated clear", irq_pend, 64'd1 << 52);
    idle(10);
    chk("R10 irq held", 64'(irq_out), 64'd1);
    wr(3'd4, 1'b1, 32'd1 << 20);
    chk("R9 irq low when code disabled", 64'(irq_out), 64'd0);
    chk("R9 pending kept", irq_pend, 64'd1 << 52);
    wr(3'd3, 1'b1, 32'd1 << 20);
    chk("R9 irq back on enable", 64'(irq_out), 64'd1);
    wr(3'd5, 1'b1, 32'd1 << 20);
    chk("R10 irq drops on clear", 64'(irq_out), 64'd0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule